// File: doc/BRIEF.md
# Edge-Select Wake-Interrupt Controller

This block watches three external interrupt pins and one port of general-purpose pins. It turns the edges it sees into latched interrupt flags, and it raises a wake request for a core that is asleep. External pin 0 reacts only to a falling edge. External pins 1 and 2 each react to either a rising or a falling edge, chosen per pin. Every port pin has its own change detector, which fires on both edges.

All pin inputs first pass through a multi-flop synchronizer. A short warm-up after reset keeps the pin levels present at reset from being taken as edges. Each source has its own enable bit. Each flag stays set until software writes a one to its clear bit. The wake output requests service whenever an enabled flag is pending.

Top module: `wakeint_top`

## Requirements
- R1: After reset every flag and the wake output are 0. The pin levels present when reset is released create no flag. Edges are accepted only after a warm-up of SYNC_STAGES+1 clock cycles.
- R2: External pin 0 sets extFlag[0] on a falling edge only. A rising edge on it sets nothing.
- R3: The flag appears on the (SYNC_STAGES+1)-th rising clock edge after the pin changes, which is the 3rd edge with the default parameters. Before that edge the flag is still 0.
- R4: extEdgeSel[k] sets the edge for external pin k+1. A value of 1 selects the rising edge and 0 selects the falling edge. The edge that is not selected sets no flag.
- R5: Port pin i sets portFlag[i] on a rising edge and on a falling edge. This holds for every pin up to the last one, PORT_W-1.
- R6: A source whose enable bit (extEn or portEn) is 0 sets no flag, whatever its pin does.
- R7: Writing 1 to a bit of extClr or portClr clears that flag on the next clock edge. Writing 0 to a clear bit leaves its flag unchanged.
- R8: When a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R9: wake is 1 exactly when at least one flag is 1 and its enable bit is 1. Clearing an enable bit drops wake while the flag itself stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | 3 | External interrupt pins (asynchronous) |
| portPin | input | PORT_W | Port pins under change detection (asynchronous) |
| extEn | input | 3 | Per-source enable for the external pins |
| extEdgeSel | input | 2 | Edge choice for external pins 1 and 2 (1 = rising) |
| portEn | input | PORT_W | Per-pin enable for change detection |
| extClr | input | 3 | Write-one-to-clear pulses for extFlag |
| portClr | input | PORT_W | Write-one-to-clear pulses for portFlag |
| extFlag | output | 3 | Latched external interrupt flags |
| portFlag | output | PORT_W | Latched pin-change flags |
| wake | output | 1 | Wake request to the core |

## Verification
The bench builds the block with its defaults: PORT_W=18 and SYNC_STAGES=2. These values put the full eighteen-pin port within reach, including the edge on the top bit. They also make the three-edge latency exact, so the bench can sample the cycle before a flag appears and the cycle it appears. The same short pipeline lets the bench align a clear write with the exact set cycle, and it exposes the warm-up window against pins held high through reset.

// File: rtl/wakeint_pkg.sv
package wakeint_pkg;
  localparam int EXT_N = 3;

  typedef struct packed {
    logic [EXT_N-1:0] set;
    logic [EXT_N-1:0] clr;
  } extStrobe_t;
endpackage

// File: rtl/wakeint_sync.sv
module wakeint_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wakeint_datapath.sv
module wakeint_datapath
  import wakeint_pkg::*;
#(
  parameter int PORT_W = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EXT_N-1:0]  extPin,
  input  logic [PORT_W-1:0] portPin,
  input  extStrobe_t        extStb,
  input  logic [PORT_W-1:0] portSet,
  input  logic [PORT_W-1:0] portClr,
  output logic [EXT_N-1:0]  extRise,
  output logic [EXT_N-1:0]  extFall,
  output logic [PORT_W-1:0] portChg,
  output logic [EXT_N-1:0]  extFlag,
  output logic [PORT_W-1:0] portFlag
);
  logic [EXT_N-1:0]  extSyncd, extPrev;
  logic [PORT_W-1:0] portSyncd, portPrev;

  wakeint_sync #(.W(EXT_N), .STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .d(extPin), .q(extSyncd));
  wakeint_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_portSync (
    .clk(clk), .rstN(rstN), .d(portPin), .q(portSyncd));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev  <= '0;
      portPrev <= '0;
      extFlag  <= '0;
      portFlag <= '0;
    end else begin
      extPrev  <= extSyncd;
      portPrev <= portSyncd;
      extFlag  <= (extFlag & ~extStb.clr) | extStb.set;
      portFlag <= (portFlag & ~portClr) | portSet;
    end
  end

  assign extRise = extSyncd & ~extPrev;
  assign extFall = ~extSyncd & extPrev;
  assign portChg = portSyncd ^ portPrev;

  // R7: a clear without a set empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((extFlag & $past(extStb.clr & ~extStb.set)) == '0) &&
              ((portFlag & $past(portClr & ~portSet)) == '0)));
  // R8: a set always lands, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((~extFlag & $past(extStb.set)) == '0) &&
              ((~portFlag & $past(portSet)) == '0)));
  // R2: pin 0 flag only follows a low synchronized level
  a_r2_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFlag[0]) |-> !$past(extSyncd[0]));
endmodule

// File: rtl/wakeint_control.sv
module wakeint_control
  import wakeint_pkg::*;
#(
  parameter int PORT_W = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EXT_N-1:0]  extRise,
  input  logic [EXT_N-1:0]  extFall,
  input  logic [PORT_W-1:0] portChg,
  input  logic [EXT_N-1:0]  extEn,
  input  logic [EXT_N-2:0]  extEdgeSel,
  input  logic [PORT_W-1:0] portEn,
  input  logic [EXT_N-1:0]  extClr,
  input  logic [PORT_W-1:0] portClr,
  output extStrobe_t        extStb,
  output logic [PORT_W-1:0] portSet,
  output logic [PORT_W-1:0] portClrStb
);
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW = $clog2(WARM + 1);

  logic [CW-1:0]    warmCnt;
  logic             armed;
  logic [EXT_N-1:0] extHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       warmCnt <= '0;
    else if (!armed) warmCnt <= warmCnt + 1'b1;
  end
  assign armed = (warmCnt == CW'(WARM));

  assign extHit[0] = extFall[0];
  for (genvar i = 1; i < EXT_N; i++) begin : g_sel
    assign extHit[i] = extEdgeSel[i-1] ? extRise[i] : extFall[i];
  end

  always_comb begin
    extStb.set = extHit & extEn & {EXT_N{armed}};
    extStb.clr = extClr;
    portSet    = portChg & portEn & {PORT_W{armed}};
    portClrStb = portClr;
  end

  // R6: no set strobe leaves for a disabled source
  a_r6_en_gate: assert property (@(posedge clk) disable iff (!rstN)
    ((extStb.set & ~extEn) == '0) && ((portSet & ~portEn) == '0));
endmodule

// File: rtl/wakeint_top.sv
module wakeint_top
  import wakeint_pkg::*;
#(
  parameter int PORT_W = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        extPin,
  input  logic [PORT_W-1:0] portPin,
  input  logic [2:0]        extEn,
  input  logic [1:0]        extEdgeSel,
  input  logic [PORT_W-1:0] portEn,
  input  logic [2:0]        extClr,
  input  logic [PORT_W-1:0] portClr,
  output logic [2:0]        extFlag,
  output logic [PORT_W-1:0] portFlag,
  output logic              wake
);
  extStrobe_t        extStb;
  logic [PORT_W-1:0] portSet, portClrStb, portChg;
  logic [EXT_N-1:0]  extRise, extFall;

  wakeint_control #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .extRise(extRise), .extFall(extFall),
    .portChg(portChg), .extEn(extEn), .extEdgeSel(extEdgeSel),
    .portEn(portEn), .extClr(extClr), .portClr(portClr),
    .extStb(extStb), .portSet(portSet), .portClrStb(portClrStb));

  wakeint_datapath #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portPin(portPin),
    .extStb(extStb), .portSet(portSet), .portClr(portClrStb),
    .extRise(extRise), .extFall(extFall), .portChg(portChg),
    .extFlag(extFlag), .portFlag(portFlag));

  assign wake = |(extFlag & extEn) | |(portFlag & portEn);

  // R9: wake needs a pending flag behind it
  a_r9_wake_src: assert property (@(posedge clk) disable iff (!rstN)
    (extFlag == '0 && portFlag == '0) |-> !wake);
endmodule

// File: tb/wakeint_top_bench.sv
module wakeint_top_bench;
  localparam int PW = 18;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] extPin = 3'b111;
  logic [PW-1:0] portPin = '0;
  logic [2:0] extEn = '0;
  logic [1:0] extEdgeSel = '0;
  logic [PW-1:0] portEn = '0;
  logic [2:0] extClr = '0;
  logic [PW-1:0] portClr = '0;
  logic [2:0] extFlag;
  logic [PW-1:0] portFlag;
  logic wake;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wakeint_top #(.PORT_W(PW), .SYNC_STAGES(2)) u_wakeint_top (
    .clk(clk), .rstN(rstN), .extPin(extPin), .portPin(portPin),
    .extEn(extEn), .extEdgeSel(extEdgeSel), .portEn(portEn),
    .extClr(extClr), .portClr(portClr), .extFlag(extFlag),
    .portFlag(portFlag), .wake(wake));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAll();
    extClr = '1; portClr = '1;
    cyc(1);
    extClr = '0; portClr = '0;
    cyc(1);
  endtask

  task automatic testReset();
    portPin = 18'h2A5A5; extPin = 3'b111;
    extEn = '1; portEn = '1; extEdgeSel = 2'b11;
    cyc(3);
    rstN = 1'b1;
    chk("R1 ext flags at reset", 32'(extFlag), 0);
    chk("R1 wake at reset", 32'(wake), 0);
    cyc(8);
    chk("R1 no port flag from reset level", 32'(portFlag), 0);
    chk("R1 no ext flag from reset level", 32'(extFlag), 0);
  endtask

  task automatic testFallOnly();
    extEn = 3'b001; portEn = '0;
    extPin[0] = 1'b0;
    cyc(2);
    chk("R3 flag not before third edge", 32'(extFlag[0]), 0);
    cyc(1);
    chk("R3 flag on third edge", 32'(extFlag[0]), 1);
    chk("R2 pin0 falling sets", 32'(extFlag), 1);
    clearAll();
    extPin[0] = 1'b1;
    cyc(5);
    chk("R2 pin0 rising ignored", 32'(extFlag), 0);
  endtask

  task automatic testEdgeSel();
    extEn = 3'b110; extEdgeSel = 2'b01;
    extPin[1] = 1'b0; extPin[2] = 1'b0;
    cyc(5);
    chk("R4 pin1 rising-sel ignores fall, pin2 fall-sel sets", 32'(extFlag), 3'b100);
    clearAll();
    extPin[1] = 1'b1; extPin[2] = 1'b1;
    cyc(5);
    chk("R4 pin1 rising-sel sets, pin2 ignores rise", 32'(extFlag), 3'b010);
    clearAll();
    extEdgeSel = 2'b10;
    extPin[1] = 1'b0; extPin[2] = 1'b0;
    cyc(5);
    chk("R4 swapped select on falling edge", 32'(extFlag), 3'b010);
    clearAll();
    extPin[1] = 1'b1; extPin[2] = 1'b1;
    cyc(5);
    chk("R4 swapped select on rising edge", 32'(extFlag), 3'b100);
    clearAll();
  endtask

  task automatic testPortChange();
    extEn = '0; portEn = '1;
    portPin = portPin ^ 18'h20001;
    cyc(5);
    chk("R5 both polarities incl top bit", 32'(portFlag), 32'h20001);
    clearAll();
    portPin = portPin ^ 18'h20001;
    cyc(5);
    chk("R5 reverse edges", 32'(portFlag), 32'h20001);
    clearAll();
  endtask

  task automatic testDisabled();
    portEn = 18'h00F0; extEn = 3'b000;
    portPin = portPin ^ 18'h3FFFF;
    extPin[0] = 1'b0;
    cyc(5);
    chk("R6 only enabled port pins flag", 32'(portFlag), 32'h00F0);
    chk("R6 disabled ext pin no flag", 32'(extFlag), 0);
    clearAll();
    extPin[0] = 1'b1;
    cyc(4);
  endtask

  task automatic testClear();
    portEn = '1; extEn = '0;
    portPin = portPin ^ 18'h00011;
    cyc(5);
    portClr = 18'h00001;
    cyc(1);
    portClr = '0;
    chk("R7 one clears, zero keeps", 32'(portFlag), 32'h00010);
    clearAll();
    chk("R7 all cleared", 32'(portFlag), 0);
  endtask

  task automatic testSetWins();
    portEn = '1;
    portPin = portPin ^ 18'h00100;
    cyc(2);
    portClr = 18'h00100;
    cyc(1);
    portClr = '0;
    chk("R8 set beats clear", 32'(portFlag), 32'h00100);
    clearAll();
  endtask

  task automatic testWake();
    portEn = '1; extEn = '0;
    chk("R9 idle wake", 32'(wake), 0);
    portPin = portPin ^ 18'h00008;
    cyc(5);
    chk("R9 wake on pending", 32'(wake), 1);
    portEn = '0;
    cyc(1);
    chk("R9 wake drops with enable", 32'(wake), 0);
    chk("R9 flag stays latched", 32'(portFlag), 32'h00008);
    portEn = '1;
    cyc(1);
    chk("R9 wake returns", 32'(wake), 1);
    clearAll();
    chk("R9 wake after clear", 32'(wake), 0);
  endtask

  initial begin
    testReset();
    testFallOnly();
    testEdgeSel();
    testPortChange();
    testDisabled();
    testClear();
    testSetWins();
    testWake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule